// File: doc/BRIEF.md
# Dual Programmable 32-bit Timer/Counter

This block is a register-mapped peripheral that holds two independent counting channels. Each channel has three registers: a control/status word, a load value and a live count. A single-cycle register port reaches them. Software can use a channel to generate a one-shot or periodic event. It can also leave a channel running without interrupts as a continuous time base that it reads back.

Each channel counts up or down by one per clock while it is enabled. Setting the load bit presets the count from the load register and holds it there. When the count passes its end, the channel raises a status flag. With auto-reload set, the channel then starts again from the load value; without it, the channel stops itself. Software clears the status flag by writing 1 to it. The interrupt output is the registered OR of the channels whose flag and interrupt enable are both set. An enable-all bit, written through either channel, starts both channels in the same cycle.

Top module: `dual_count_timer`

## Requirements
- R1: After the synchronous active-high reset, every register reads 0 and `irq` is 0.
- R2: A read presents data on `reg_rdata` one cycle after the address is applied. Channel c uses byte offset 0x10*c for control/status, 0x10*c+4 for load and 0x10*c+8 for count. The control/status word holds these fields: bit1 down, bit4 auto-reload, bit5 load, bit6 interrupt enable, bit7 enable, bit8 status. All other control bits read as 0 and store nothing.
- R3: While the load bit is set, the count takes the load register value on every clock and does not count.
- R4: While enable is 1 and load is 0, the count changes by one each clock. It decrements when the down bit is 1 and increments when the down bit is 0.
- R5: A terminal event occurs when the count is 0 while counting down, or is all ones while counting up. The event sets the status bit at that same clock edge. With auto-reload set, the count takes the load value at that edge and the channel stays enabled.
- R6: Without auto-reload, a terminal event lets the count wrap (to 0 when counting up) and clears the channel's enable bit, giving one-shot operation.
- R7: Writing a control word with bit8 = 1 clears the status bit.
- R8: `irq` is 1 in the cycle after some channel has both interrupt enable and status set, and 0 otherwise. A channel whose interrupt enable is 0 never raises it.
- R9: Clearing the enable bit stops the channel, and its count keeps its value.
- R10: Writing a control word with bit10 = 1 to either channel sets the enable bit of every channel at that edge. The other fields of the untargeted channels are unchanged.
- R11: Offsets 0xC and 0x1C, and any offset not aligned to 4 bytes, read as 0 and ignore writes. The count register is read-only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 5 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data for the address of the previous cycle |
| irq | output | 1 | Registered interrupt request |

## Verification
The count is tried from several starting points:
- A small down-count with auto-reload shows the exact step sequence, the reload value and the interval of the periodic event.
- An up-count started just below all ones separates the wrap-and-stop behaviour from reload, and confirms that a flag with its interrupt disabled leaves `irq` low.
- A held load bit, with the load value changed under it, shows that the preset tracks the register rather than counting.
- A stop in the middle of a count shows that the value is frozen.

The enable-all write and writes to unmapped offsets and unused bits are checked at the read port for their effect on both channels.

// File: rtl/dct_pkg.sv
package dct_pkg;
  localparam int BIT_DOWN = 1;
  localparam int BIT_AR   = 4;
  localparam int BIT_LD   = 5;
  localparam int BIT_IE   = 6;
  localparam int BIT_EN   = 7;
  localparam int BIT_ST   = 8;
  localparam int BIT_ALL  = 10;
  localparam int CTRL_W   = 11;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LOAD = 2'd1,
    SEL_CNT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic down;
    logic ar;
    logic ld;
    logic ie;
    logic en;
    logic st;
  } ctrl_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(input ctrl_t c);
    logic [CTRL_W-1:0] v;
    v = '0;
    v[BIT_DOWN] = c.down;
    v[BIT_AR]   = c.ar;
    v[BIT_LD]   = c.ld;
    v[BIT_IE]   = c.ie;
    v[BIT_EN]   = c.en;
    v[BIT_ST]   = c.st;
    return v;
  endfunction
endpackage

// File: rtl/dct_decode.sv
module dct_decode #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic                 wr,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 all_bit,
  output dct_pkg::reg_sel_e    sel,
  output logic [ADDR_W-5:0]    idx,
  output logic [NUM_CH-1:0]    ctrl_wr,
  output logic [NUM_CH-1:0]    load_wr,
  output logic                 all_set
);
  import dct_pkg::*;

  logic mapped;

  always_comb begin
    idx    = addr[ADDR_W-1:4];
    mapped = (addr[1:0] == 2'b00) && (addr[3:2] != 2'b11) && (32'(idx) < NUM_CH);
    sel    = mapped ? reg_sel_e'(addr[3:2]) : SEL_NONE;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_wr
    assign ctrl_wr[c] = wr && (sel == SEL_CTRL) && (32'(idx) == c);
    assign load_wr[c] = wr && (sel == SEL_LOAD) && (32'(idx) == c);
  end

  assign all_set = wr && (sel == SEL_CTRL) && all_bit;
endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ctrl_wr,
  input  logic           load_wr,
  input  logic [W-1:0]   wdata,
  input  logic           all_set,
  output dct_pkg::ctrl_t ctrl,
  output logic [W-1:0]   load_val,
  output logic [W-1:0]   cnt
);
  import dct_pkg::*;

  logic term;

  always_comb begin
    term = ctrl.en && !ctrl.ld &&
           (ctrl.down ? (cnt == '0) : (cnt == {W{1'b1}}));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl     <= '0;
      load_val <= '0;
      cnt      <= '0;
    end else begin
      if (load_wr) load_val <= wdata;

      if (ctrl.ld)
        cnt <= load_val;
      else if (ctrl.en) begin
        if (term && ctrl.ar) cnt <= load_val;
        else if (ctrl.down)  cnt <= cnt - 1'b1;
        else                 cnt <= cnt + 1'b1;
      end

      if (ctrl_wr) begin
        ctrl.down <= wdata[BIT_DOWN];
        ctrl.ar   <= wdata[BIT_AR];
        ctrl.ld   <= wdata[BIT_LD];
        ctrl.ie   <= wdata[BIT_IE];
        ctrl.en   <= wdata[BIT_EN];
      end else if (term && !ctrl.ar) begin
        ctrl.en <= 1'b0;
      end
      if (all_set) ctrl.en <= 1'b1;

      if (term)                            ctrl.st <= 1'b1;
      else if (ctrl_wr && wdata[BIT_ST])   ctrl.st <= 1'b0;
    end
  end
endmodule

// File: rtl/dct_readmux.sv
module dct_readmux #(
  parameter int W      = 32,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic                           clk,
  input  logic                           rst,
  input  dct_pkg::reg_sel_e              sel,
  input  logic [ADDR_W-5:0]              idx,
  input  dct_pkg::ctrl_t [NUM_CH-1:0]    ctrl_a,
  input  logic [NUM_CH-1:0][W-1:0]       load_a,
  input  logic [NUM_CH-1:0][W-1:0]       cnt_a,
  output logic [W-1:0]                   rdata
);
  import dct_pkg::*;

  logic [W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (32'(idx) == c) begin
        case (sel)
          SEL_CTRL: rd_next = {{(W-CTRL_W){1'b0}}, pack_ctrl(ctrl_a[c])};
          SEL_LOAD: rd_next = load_a[c];
          SEL_CNT:  rd_next = cnt_a[c];
          default:  rd_next = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/dual_count_timer.sv
module dual_count_timer #(
  parameter int W      = 32,
  parameter int NUM_CH = 2,
  localparam int ADDR_W = $clog2(NUM_CH) + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq
);
  import dct_pkg::*;

  reg_sel_e                 sel;
  logic [ADDR_W-5:0]        idx;
  logic [NUM_CH-1:0]        ctrl_wr, load_wr;
  logic                     all_set;
  ctrl_t [NUM_CH-1:0]       ctrl_a;
  logic [NUM_CH-1:0][W-1:0] load_a, cnt_a;
  logic                     irq_next;

  dct_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
    .wr(reg_wr), .addr(reg_addr), .all_bit(reg_wdata[BIT_ALL]),
    .sel(sel), .idx(idx), .ctrl_wr(ctrl_wr), .load_wr(load_wr), .all_set(all_set)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dct_channel #(.W(W)) u_ch (
      .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr[c]), .load_wr(load_wr[c]),
      .wdata(reg_wdata), .all_set(all_set),
      .ctrl(ctrl_a[c]), .load_val(load_a[c]), .cnt(cnt_a[c])
    );
  end

  dct_readmux #(.W(W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .sel(sel), .idx(idx),
    .ctrl_a(ctrl_a), .load_a(load_a), .cnt_a(cnt_a), .rdata(reg_rdata)
  );

  always_comb begin
    irq_next = 1'b0;
    for (int c = 0; c < NUM_CH; c++) irq_next |= ctrl_a[c].ie & ctrl_a[c].st;
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_next;
  end
endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int W      = 32,
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     reg_wr,
  input logic [ADDR_W-1:0]        reg_addr,
  input logic [W-1:0]             reg_wdata,
  input logic [W-1:0]             reg_rdata,
  input dct_pkg::ctrl_t [NUM_CH-1:0] ctrl_a,
  input logic [NUM_CH-1:0][W-1:0] load_a,
  input logic [NUM_CH-1:0][W-1:0] cnt_a
);
  logic wr_ctrl_all;
  assign wr_ctrl_all = reg_wr && (reg_addr[3:0] == 4'h0) && reg_wdata[10];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    // R3
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_a[c].ld |=> cnt_a[c] == $past(load_a[c]));
    // R9
    cnt_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_a[c].en && !ctrl_a[c].ld) |=> $stable(cnt_a[c]));
    // R5
    status_from_run_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(ctrl_a[c].st) |-> $past(ctrl_a[c].en));
    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(ctrl_a[c].st) && !$past(ctrl_a[c].ar) && !$past(reg_wr)) |-> !ctrl_a[c].en);
    // R10
    enable_all_chk: assert property (@(posedge clk) disable iff (rst)
      wr_ctrl_all |=> ctrl_a[c].en);
  end

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(reg_addr[3:2] == 2'b11 || reg_addr[1:0] != 2'b00) |-> reg_rdata == '0);
endmodule

bind dual_count_timer dct_checker #(.W(W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata), .ctrl_a(ctrl_a), .load_a(load_a), .cnt_a(cnt_a)
);

// File: tb/dual_count_timer_bench.sv
module dual_count_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  int n_chk = 0;
  int n_fail = 0;
  logic done = 1'b0;

  localparam logic [31:0] DN = 32'h2, AR = 32'h10, LD = 32'h20, IE = 32'h40,
                          EN = 32'h80, ST = 32'h100, ALL = 32'h400;
  localparam logic [4:0] C0 = 5'h00, L0 = 5'h04, K0 = 5'h08,
                         C1 = 5'h10, L1 = 5'h14, K1 = 5'h18;

  always #2 clk = ~clk;

  dual_count_timer u_dual_count_timer (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk); @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(a, d);
    chk(d == exp, req, d, exp);
  endtask

  task automatic t_reset();
    chk(irq == 1'b0, "R1 irq", {31'b0, irq}, 32'h0);
    rd_chk(C0, 32'h0, "R1 ctrl0");
    rd_chk(K1, 32'h0, "R1 cnt1");
    rd_chk(L0, 32'h0, "R1 load0");
  endtask

  task automatic t_periodic();
    wr(L0, 32'd5);
    wr(C0, LD);
    wr(C0, EN | DN | AR | IE | ST);
    for (int i = 5; i >= 0; i--) rd_chk(K0, i, "R4 down step");
    rd_chk(C0, EN | DN | AR | IE | ST, "R5 status set, still enabled");
    chk(irq == 1'b1, "R8 irq raised", {31'b0, irq}, 32'h1);
    rd_chk(K0, 32'd4, "R5 reload then count");
    wr(C0, EN | DN | AR | IE | ST);
    rd_chk(C0, EN | DN | AR | IE, "R7 write-1 clear");
    chk(irq == 1'b0, "R8 irq dropped", {31'b0, irq}, 32'h0);
    wr(C0, 32'h0);
    wr(C0, ST);
  endtask

  task automatic t_oneshot();
    wr(L1, 32'hFFFF_FFFD);
    wr(C1, LD);
    wr(C1, EN);
    rd_chk(K1, 32'hFFFF_FFFD, "R4 up step");
    rd_chk(K1, 32'hFFFF_FFFE, "R4 up step");
    rd_chk(K1, 32'hFFFF_FFFF, "R4 up step");
    rd_chk(K1, 32'h0, "R6 wrap");
    rd_chk(K1, 32'h0, "R6 stopped");
    rd_chk(C1, ST, "R6 enable cleared, status set");
    chk(irq == 1'b0, "R8 masked", {31'b0, irq}, 32'h0);
    wr(C1, ST);
    rd_chk(C1, 32'h0, "R7 clear");
  endtask

  task automatic t_freeze();
    wr(L1, 32'h0);
    wr(C1, LD);
    wr(C1, EN);
    rd_chk(K1, 32'd0, "R3 preset");
    rd_chk(K1, 32'd1, "R4 up");
    rd_chk(K1, 32'd2, "R4 up");
    wr(C1, 32'h0);
    rd_chk(K1, 32'd4, "R9 frozen");
    rd_chk(K1, 32'd4, "R9 frozen");
  endtask

  task automatic t_loadhold();
    logic [31:0] d;
    wr(L0, 32'h1234);
    wr(C0, LD | EN);
    rd(K0, d);
    rd_chk(K0, 32'h1234, "R3 hold");
    rd_chk(K0, 32'h1234, "R3 hold");
    wr(L0, 32'h55);
    rd(K0, d);
    rd_chk(K0, 32'h55, "R3 track load");
    wr(C0, 32'h0);
    wr(K0, 32'hDEAD);
    rd_chk(K0, 32'h55, "R11 count read-only");
  endtask

  task automatic t_enall();
    wr(C1, DN | IE);
    wr(C0, ALL);
    rd_chk(C0, EN, "R10 ch0 enabled");
    rd_chk(C1, DN | IE | EN, "R10 ch1 enabled");
    wr(C1, 32'h0);
    wr(C0, 32'h0);
    wr(C1, ST);
    wr(C0, ST);
  endtask

  task automatic t_unmapped();
    wr(5'h0C, 32'hFFFF_FFFF);
    rd_chk(5'h0C, 32'h0, "R11 hole 0x0C");
    rd_chk(L0, 32'h55, "R11 write ignored");
    wr(5'h1C, 32'hFFFF_FFFF);
    rd_chk(5'h1C, 32'h0, "R11 hole 0x1C");
    wr(5'h05, 32'hFFFF_FFFF);
    rd_chk(L0, 32'h55, "R11 unaligned ignored");
    rd_chk(5'h05, 32'h0, "R11 unaligned reads 0");
    wr(C0, 32'h20D);
    rd_chk(C0, 32'h0, "R2 unused bits");
    wr(C1, DN | AR | IE);
    rd_chk(C1, DN | AR | IE, "R2 field positions");
    wr(C1, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_periodic();
        t_oneshot();
        t_freeze();
        t_loadhold();
        t_enall();
        t_unmapped();
        done = 1'b1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          n_chk++;
          n_fail++;
          $display("FAIL watchdog: actual timeout expected completion");
        end
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule